// File: doc/BRIEF.md
# Reorder-Buffer Entry Sharing Unit

This block looks at one cycle's group of decoded micro-ops, six lanes by default, and decides which neighbouring lanes may be folded into a single reorder buffer entry. A lane is a candidate for sharing only when it is a complete, fault-free, unfused instruction that the decoder marked as shareable. Each unbroken stretch of candidate lanes becomes one entry. The entry is owned by the highest lane of that stretch.

For every lane the unit reports three things. The first is whether that lane must claim a reorder buffer slot of its own. The second is how many instructions the lane's entry holds. The third is a bit mask of the lanes that share the entry. The index allocator downstream reads the first output to hand out consecutive slots. The reorder buffer reads the other two to learn how many instructions each entry retires and which lanes those are. The unit is purely combinational, so all outputs follow the inputs within the same cycle.

Top module: `rob_share_unit`

## Requirements
- R1: A lane is shareable only when all five of these hold: valid is 1, fused is 0, last-uop is 1, the exception summary is 0, and the share hint is 1. If any one of them fails, the lane is treated as non-shareable.
- R2: `need_entry[n]` is 1 for every non-shareable lane n.
- R3: For a shareable lane, `need_entry[n]` is 1 only when n is the highest lane of its contiguous shareable run. Lane LANES-1 always ends any run that reaches it.
- R4: `entry_size` for lane n, held in bits [n*SZ_W +: SZ_W], is 1 for a non-shareable lane. For a shareable lane it equals the length of that lane's run.
- R5: `share_mask` for a non-shareable lane n, held in bits [n*LANES +: LANES], has only bit n set.
- R6: For a shareable lane, the mask has exactly the bits of every lane in its run set. Every lane of one run reports the same mask.
- R7: All outputs are combinational functions of the present inputs, with no storage and no clock.
- R8: An invalid lane reports `need_entry` 1, size 1 and a self-only mask, whatever its other inputs are.
- R9: Runs are split only where two neighbouring lanes are not both shareable. A single non-shareable lane between two shareable stretches gives two separate entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_valid | input | LANES | Lane carries a decoded micro-op |
| lane_fused | input | LANES | Lane belongs to a fused pair |
| lane_last | input | LANES | Lane is the final micro-op of its instruction |
| lane_excp | input | LANES | OR of the lane's exception bits |
| lane_hint | input | LANES | Decoder marks the lane as shareable |
| need_entry | output | LANES | Lane must claim its own reorder buffer entry |
| entry_size | output | LANES*SZ_W | Per-lane count of instructions in its entry |
| share_mask | output | LANES*LANES | Per-lane mask of the lanes in its entry |

## Verification
The bench applies every one of the 64 shareable patterns and compares each against a run-scanning model. This shows whether runs are split only at gaps, and whether the top lane ends a run that reaches it. A small set of fixed patterns is also tried. A mixed pattern with known expected values pins down the exact outputs. An all-shareable group exposes any miscount of the full-width run. An alternating group shows that isolated shareable lanes behave like non-shareable ones. Separate scenarios break exactly one qualifier on a lane in the middle of an otherwise shareable group, which tells the five qualifying conditions apart. Invalid lanes with every other input set confirm that their outputs are fixed.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
   localparam int RSU_DEF_LANES = 6;

   function automatic int rsu_size_width(input int lanes);
      return $clog2(lanes + 1);
   endfunction
endpackage

// File: rtl/rsu_lane_qualify.sv
module rsu_lane_qualify #(
   parameter int LANES = rsu_pkg::RSU_DEF_LANES
) (
   input  logic [LANES-1:0] lane_valid,
   input  logic [LANES-1:0] lane_fused,
   input  logic [LANES-1:0] lane_last,
   input  logic [LANES-1:0] lane_excp,
   input  logic [LANES-1:0] lane_hint,
   output logic [LANES-1:0] shareable
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign shareable[g] = lane_valid[g] & ~lane_fused[g] & lane_last[g]
                          & ~lane_excp[g] & lane_hint[g];
   end
endmodule

// File: rtl/rsu_run_span.sv
module rsu_run_span #(
   parameter int LANES = rsu_pkg::RSU_DEF_LANES
) (
   input  logic [LANES-1:0]       shareable,
   output logic [LANES*LANES-1:0] span_mask,
   output logic [LANES-1:0]       run_end
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANES-1:0] m;
      always_comb begin
         logic alive;
         m    = '0;
         m[g] = 1'b1;
         alive = shareable[g];
         for (int k = g + 1; k < LANES; k++) begin
            alive = alive & shareable[k];
            if (alive) m[k] = 1'b1;
         end
         alive = shareable[g];
         for (int k = g - 1; k >= 0; k--) begin
            alive = alive & shareable[k];
            if (alive) m[k] = 1'b1;
         end
      end
      assign span_mask[g*LANES +: LANES] = m;

      if (g == LANES - 1) begin : g_top
         assign run_end[g] = 1'b1;
      end else begin : g_mid
         assign run_end[g] = ~shareable[g] | ~shareable[g+1];
      end
   end
endmodule

// File: rtl/rsu_size_count.sv
module rsu_size_count #(
   parameter int LANES = rsu_pkg::RSU_DEF_LANES,
   parameter int SZ_W  = rsu_pkg::rsu_size_width(LANES)
) (
   input  logic [LANES*LANES-1:0] span_mask,
   output logic [LANES*SZ_W-1:0]  entry_size
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [SZ_W-1:0] cnt;
      always_comb begin
         cnt = '0;
         for (int k = 0; k < LANES; k++)
            cnt = cnt + SZ_W'(span_mask[g*LANES + k]);
      end
      assign entry_size[g*SZ_W +: SZ_W] = cnt;
   end
endmodule

// File: rtl/rob_share_unit.sv
module rob_share_unit #(
   parameter int LANES = rsu_pkg::RSU_DEF_LANES,
   parameter int SZ_W  = rsu_pkg::rsu_size_width(LANES)
) (
   input  logic [LANES-1:0]       lane_valid,
   input  logic [LANES-1:0]       lane_fused,
   input  logic [LANES-1:0]       lane_last,
   input  logic [LANES-1:0]       lane_excp,
   input  logic [LANES-1:0]       lane_hint,
   output logic [LANES-1:0]       need_entry,
   output logic [LANES*SZ_W-1:0]  entry_size,
   output logic [LANES*LANES-1:0] share_mask
);
   if (LANES < 2) begin : g_bad_lanes
      $error("rob_share_unit: LANES must be at least 2");
   end
   if (SZ_W < $clog2(LANES + 1)) begin : g_bad_szw
      $error("rob_share_unit: SZ_W too narrow for LANES");
   end

   logic [LANES-1:0] shareable;
   logic [LANES-1:0] run_end;

   rsu_lane_qualify #(.LANES(LANES)) u_qual (
      .lane_valid (lane_valid),
      .lane_fused (lane_fused),
      .lane_last  (lane_last),
      .lane_excp  (lane_excp),
      .lane_hint  (lane_hint),
      .shareable  (shareable)
   );

   rsu_run_span #(.LANES(LANES)) u_span (
      .shareable (shareable),
      .span_mask (share_mask),
      .run_end   (run_end)
   );

   rsu_size_count #(.LANES(LANES), .SZ_W(SZ_W)) u_size (
      .span_mask  (share_mask),
      .entry_size (entry_size)
   );

   assign need_entry = run_end;
endmodule

// File: rtl/rsu_share_chk.sv
module rsu_share_chk #(
   parameter int LANES = rsu_pkg::RSU_DEF_LANES,
   parameter int SZ_W  = rsu_pkg::rsu_size_width(LANES)
) (
   input logic [LANES-1:0]       lane_valid,
   input logic [LANES-1:0]       lane_fused,
   input logic [LANES-1:0]       lane_last,
   input logic [LANES-1:0]       lane_excp,
   input logic [LANES-1:0]       lane_hint,
   input logic [LANES-1:0]       need_entry,
   input logic [LANES*SZ_W-1:0]  entry_size,
   input logic [LANES*LANES-1:0] share_mask
);
   always_comb begin
      if (!$isunknown({lane_valid, lane_fused, lane_last, lane_excp, lane_hint,
                       need_entry, entry_size, share_mask})) begin
         for (int n = 0; n < LANES; n++) begin
            logic [LANES-1:0] m;
            m = share_mask[n*LANES +: LANES];
            // R5 / R6: a lane always belongs to its own entry
            a_r5_self_bit: assert (m[n]);
            // R2: any failed qualifier forces an own entry
            a_r2_nonshare_needs: assert (!(!lane_valid[n] || lane_fused[n] || !lane_last[n]
                                    || lane_excp[n] || !lane_hint[n]) || need_entry[n]);
            // R3: exactly one owning lane per entry
            a_r3_one_owner: assert ($countones(m & need_entry) == 1);
            // R4: size agrees with the membership mask
            a_r4_size_is_members: assert (32'(entry_size[n*SZ_W +: SZ_W]) == $countones(m));
            // R8: invalid lanes stand alone
            a_r8_invalid_alone: assert (lane_valid[n] ||
                                    (need_entry[n] && m == (LANES'(1) << n)));
            for (int k = 0; k < LANES; k++) begin
               // R6: lanes of one run agree on membership
               a_r6_mask_symmetric: assert (share_mask[n*LANES + k] == share_mask[k*LANES + n]);
            end
         end
      end
   end
endmodule

bind rob_share_unit rsu_share_chk #(.LANES(LANES), .SZ_W(SZ_W)) u_chk (
   .lane_valid (lane_valid),
   .lane_fused (lane_fused),
   .lane_last  (lane_last),
   .lane_excp  (lane_excp),
   .lane_hint  (lane_hint),
   .need_entry (need_entry),
   .entry_size (entry_size),
   .share_mask (share_mask)
);

// File: tb/rob_share_unit_test.sv
module rob_share_unit_test;
   localparam int L  = 6;
   localparam int SW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [L-1:0]    v, f, la, ex, h;
   logic [L-1:0]    need;
   logic [L*SW-1:0] size;
   logic [L*L-1:0]  mask;

   int checks = 0;
   int errors = 0;

   rob_share_unit uut (
      .lane_valid (v), .lane_fused (f), .lane_last (la),
      .lane_excp  (ex), .lane_hint (h),
      .need_entry (need), .entry_size (size), .share_mask (mask)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive inputs off the edge, sample after settling
   task automatic apply(input logic [L-1:0] vv, ff, ll, ee, hh);
      @(negedge clk);
      v = vv; f = ff; la = ll; ex = ee; h = hh;
      #2;
   endtask

   // run-scanning model built from the requirements
   task automatic check_model(input string req, input logic [L-1:0] comp);
      for (int i = 0; i < L; i++) begin
         int lo, hi;
         logic [L-1:0] em;
         int en, es;
         if (!comp[i]) begin
            en = 1; es = 1; em = L'(1) << i;
         end else begin
            lo = i; hi = i;
            while (lo > 0 && comp[lo-1]) lo--;
            while (hi < L-1 && comp[hi+1]) hi++;
            em = '0;
            for (int k = lo; k <= hi; k++) em[k] = 1'b1;
            es = hi - lo + 1;
            en = (i == hi) ? 1 : 0;
         end
         chk(req, $sformatf("lane%0d need", i), int'(need[i]), en);
         chk(req, $sformatf("lane%0d size", i), int'(size[i*SW +: SW]), es);
         chk(req, $sformatf("lane%0d mask", i), int'(mask[i*L +: L]), int'(em));
      end
   endtask

   task automatic t_reset;
      // reset state: all lanes idle -> R8 outputs
      check_model("R8", '0);
   endtask

   task automatic t_known_pattern;
      apply(6'b111111, 6'b000000, 6'b111111, 6'b000000, 6'b100110);
      chk("R3", "need vector", int'(need), 6'b111101);
      chk("R4", "size lane2", int'(size[2*SW +: SW]), 2);
      chk("R4", "size lane1", int'(size[1*SW +: SW]), 2);
      chk("R4", "size lane5", int'(size[5*SW +: SW]), 1);
      chk("R6", "mask lane1", int'(mask[1*L +: L]), 6'b000110);
      chk("R6", "mask lane2", int'(mask[2*L +: L]), 6'b000110);
      chk("R5", "mask lane0", int'(mask[0*L +: L]), 6'b000001);
   endtask

   task automatic t_full_run;
      apply('1, '0, '1, '0, '1);
      chk("R3", "need full run", int'(need), 6'b100000);
      chk("R4", "size lane0 full", int'(size[0*SW +: SW]), 6);
      chk("R6", "mask lane3 full", int'(mask[3*L +: L]), 6'b111111);
   endtask

   task automatic t_alternate;
      apply('1, '0, '1, '0, 6'b010101);
      check_model("R9", 6'b010101);
   endtask

   task automatic t_qualifiers;
      // break one condition on lane 2 of an all-shareable group
      apply(6'b111011, '0, '1, '0, '1);
      check_model("R1", 6'b111011);
      apply('1, 6'b000100, '1, '0, '1);
      check_model("R1", 6'b111011);
      apply('1, '0, 6'b111011, '0, '1);
      check_model("R1", 6'b111011);
      apply('1, '0, '1, 6'b000100, '1);
      check_model("R1", 6'b111011);
      apply('1, '0, '1, '0, 6'b111011);
      check_model("R2", 6'b111011);
   endtask

   task automatic t_invalid_lanes;
      // invalid lanes with everything else asserted
      apply(6'b011110, '0, '1, '0, '1);
      chk("R8", "lane0 need", int'(need[0]), 1);
      chk("R8", "lane5 mask", int'(mask[5*L +: L]), 6'b100000);
      chk("R8", "lane5 size", int'(size[5*SW +: SW]), 1);
      check_model("R8", 6'b011110);
   endtask

   task automatic t_sweep;
      // R7: outputs follow every new input with no clock in between
      for (int p = 0; p < 64; p++) begin
         apply('1, '0, '1, '0, 6'(p));
         check_model("R7", 6'(p));
      end
   endtask

   initial begin
      v = '0; f = '0; la = '0; ex = '0; h = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #2;
      t_reset();
      t_known_pattern();
      t_full_run();
      t_alternate();
      t_qualifiers();
      t_invalid_lanes();
      t_sweep();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule